// File: doc/BRIEF.md
# Compare-Match Wake-Up Timer

This block keeps a 32-bit wake-up count that advances once per slow timer strobe. It compares that count against four programmable 32-bit fields, A to D, and also detects the count wrapping past full scale. Each of these five sources has a pending bit that is set when its event happens. An enable mask selects which pending bits drive the single interrupt output. Software reaches every setting through a small word-addressed register port on the system clock. Each 32-bit value is split into a low register and a high register.

Field A re-arms itself. When it matches, it moves forward by a programmable 12-bit interval, so a periodic wake-up needs no software action. Clearing interrupts follows the slow timer domain. A write-one-to-clear request is held by a three-state sequencer:

- `CLR_IDLE` moves to `CLR_WAIT1` on a clear write.
- `CLR_WAIT1` moves to `CLR_WAIT2` on a strobe.
- `CLR_WAIT2` moves to `CLR_IDLE` on a strobe, which applies the clear. If a new request is written in that same cycle, it moves to `CLR_WAIT1` instead.

A status busy flag is high in every state except `CLR_IDLE`. While it is high, power-down sequencing must wait.

The counter has two modes:

- Free-running: the count keeps going and wraps.
- Restart: the count returns to zero on the strobe after it reaches any compare field.

Reading the low count register captures the high half, so that two 16-bit reads give one coherent value.

Top module: `wake_cmp_timer`

## Requirements
- R1: After reset the count reads 0, control reads 0x0040, the interval reads 0x00C8, field A reads 0x000000C8, field B reads 0x00001FFF, field C reads 0x00002FFF, field D reads 0x00003FFF, and the enable and status registers read 0.
- R2: While control bit 7 is 1, each strobe on `tick` adds one to the count. One clock after bit 7 is written to 0, the count is 0, and it stays 0 while bit 7 is 0.
- R3: A compare event sets the pending bit of its field (A bit 0, B bit 1, C bit 2, D bit 3) on the strobe where the count steps to that field's value. This happens whatever the enable mask holds.
- R4: In free-running mode (control bit 6 = 1), the strobe that wraps the count from all ones to zero sets pending bit 4.
- R5: In restart mode (control bit 6 = 0), the strobe after the count equals any compare field loads the count with zero.
- R6: On a field A event, field A becomes its old value plus the 12-bit interval, unless field A is being written in that cycle.
- R7: `irq` is high exactly when some pending bit has its enable bit (same bit positions) set.
- R8: Writing ones to the clear register clears those pending bits on the second strobe after the write. Status bit 6 is 1 from the clock after the write until that strobe.
- R9: If an event and an applied clear of the same bit fall on the same strobe, the bit stays set.
- R10: Reading the low count register latches the high half of the count. The high count register returns that latched half.
- R11: The word addresses are as follows:
  - 0: count low
  - 1: count high
  - 2: control
  - 3: interval
  - 4, 5: field A low, high
  - 6, 7: field B low, high
  - 8, 9: field C low, high
  - 10, 11: field D low, high
  - 12: enable
  - 13: status, with pending bits in [4:0]
  - 14: clear, which is write-only

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe per slow timer period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, used to latch the high count half |
| addr | input | 4 | Register word address |
| wdata | input | DW (16) | Write data |
| rdata | output | DW (16) | Read data for `addr`, combinational |
| irq | output | 1 | OR of the enabled pending bits |

## Verification
The bench builds the block with `HALF_W = 8`, which gives a 16-bit count split into 8-bit halves, and leaves every other parameter at its default. With that width, the wrap from all ones to zero comes within about 65 thousand back-to-back strobes, so the full-scale event can be observed directly. The high-half latch also gets exercised, when the low half rolls over at 0xFF. The default 12-bit interval and the reset field values still fit the narrower count, so the reset checks use the same values as the full-width build.

// File: rtl/wct_pkg.sv
`timescale 1ns/1ps
package wct_pkg;
    localparam int NSRC     = 5;
    localparam int SRC_A    = 0;
    localparam int SRC_FULL = 4;
    localparam int BUSY_BIT = 6;
    localparam int FREE_BIT = 6;
    localparam int RUN_BIT  = 7;
    localparam int ADDR_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_LO = 4'd0,  RA_CNT_HI = 4'd1,  RA_CTRL   = 4'd2,  RA_STEP = 4'd3,
        RA_A_LO   = 4'd4,  RA_A_HI   = 4'd5,  RA_B_LO   = 4'd6,  RA_B_HI = 4'd7,
        RA_C_LO   = 4'd8,  RA_C_HI   = 4'd9,  RA_D_LO   = 4'd10, RA_D_HI = 4'd11,
        RA_IEN    = 4'd12, RA_STAT   = 4'd13, RA_CLR    = 4'd14
    } reg_addr_e;

    typedef enum logic [1:0] {
        CLR_IDLE  = 2'd0,
        CLR_WAIT1 = 2'd1,
        CLR_WAIT2 = 2'd2
    } clr_state_e;
endpackage

// File: rtl/wct_counter.sv
`timescale 1ns/1ps
module wct_counter
    import wct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 12,
    parameter logic [CNT_W-1:0] A_INIT = 'h00C8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_req,
    input  logic              free_run,
    input  logic [CNT_W-1:0]  fld_b,
    input  logic [CNT_W-1:0]  fld_c,
    input  logic [CNT_W-1:0]  fld_d,
    input  logic [STEP_W-1:0] step,
    input  logic              a_wr,
    input  logic [CNT_W-1:0]  a_wdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  field_a,
    output logic [NSRC-1:0]   events
);
    localparam int NCMP = 4;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cmp_val [NCMP];
    logic [NCMP-1:0]  at_cmp;
    logic [NCMP-1:0]  to_cmp;
    logic [CNT_W-1:0] next_cnt;
    logic             stepping;

    assign cmp_val[0] = field_a;
    assign cmp_val[1] = fld_b;
    assign cmp_val[2] = fld_c;
    assign cmp_val[3] = fld_d;

    assign stepping = run_req && tick;
    assign next_cnt = (!free_run && (|at_cmp)) ? '0 : count + ONE;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign at_cmp[i] = (count == cmp_val[i]);
        assign to_cmp[i] = (next_cnt == cmp_val[i]);
    end

    always_comb begin
        events                  = '0;
        events[NCMP-1:0]        = stepping ? to_cmp : '0;
        events[SRC_FULL]        = stepping && free_run && (&count);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run_req) begin
            count <= '0;
        end else if (tick) begin
            count <= next_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_a <= A_INIT;
        end else if (a_wr) begin
            field_a <= a_wdata;
        end else if (events[SRC_A]) begin
            field_a <= field_a + CNT_W'(step);
        end
    end
endmodule

// File: rtl/wct_irq.sv
`timescale 1ns/1ps
module wct_irq
    import wct_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NSRC-1:0] events,
    input  logic [NSRC-1:0] irq_en,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] pending,
    output logic            busy,
    output logic            irq
);
    clr_state_e      st_q, st_d;
    logic [NSRC-1:0] mask_q;
    logic            new_req;
    logic            apply;

    assign new_req = clr_wr && (|clr_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CLR_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CLR_IDLE:  if (new_req) st_d = CLR_WAIT1;
            CLR_WAIT1: if (tick)    st_d = CLR_WAIT2;
            CLR_WAIT2: if (tick)    st_d = new_req ? CLR_WAIT1 : CLR_IDLE;
            default:                st_d = CLR_IDLE;
        endcase
    end

    always_comb begin
        busy  = (st_q != CLR_IDLE);
        apply = (st_q == CLR_WAIT2) && tick;
        irq   = |(pending & irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            pending <= '0;
        end else begin
            if (apply)       mask_q <= clr_wr ? clr_mask : '0;
            else if (clr_wr) mask_q <= mask_q | clr_mask;
            pending <= (pending & ~(apply ? mask_q : '0)) | events;
        end
    end
endmodule

// File: rtl/wake_cmp_timer.sv
`timescale 1ns/1ps
module wake_cmp_timer
    import wct_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DW     = 16,
    parameter int STEP_W = 12,
    parameter logic [2*HALF_W-1:0] A_INIT = 'h00C8,
    parameter logic [2*HALF_W-1:0] B_INIT = 'h1FFF,
    parameter logic [2*HALF_W-1:0] C_INIT = 'h2FFF,
    parameter logic [2*HALF_W-1:0] D_INIT = 'h3FFF,
    parameter logic [STEP_W-1:0]   STEP_INIT = 'h0C8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    logic              run_q, free_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  fld_b_q, fld_c_q, fld_d_q;
    logic [NSRC-1:0]   ien_q;
    logic [HALF_W-1:0] hi_hold_q;
    logic [CNT_W-1:0]  count, field_a, a_wdata;
    logic [NSRC-1:0]   events, pending;
    logic              busy, a_wr, clr_wr;
    logic [HALF_W-1:0] wd_half;

    assign wd_half = wdata[HALF_W-1:0];
    assign a_wr    = wr_en && (addr == RA_A_LO || addr == RA_A_HI);
    assign a_wdata = (addr == RA_A_LO) ? {field_a[CNT_W-1:HALF_W], wd_half}
                                       : {wd_half, field_a[HALF_W-1:0]};
    assign clr_wr  = wr_en && (addr == RA_CLR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            free_q  <= 1'b1;
            step_q  <= STEP_INIT;
            fld_b_q <= B_INIT;
            fld_c_q <= C_INIT;
            fld_d_q <= D_INIT;
            ien_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL: begin
                    run_q  <= wdata[RUN_BIT];
                    free_q <= wdata[FREE_BIT];
                end
                RA_STEP: step_q <= wdata[STEP_W-1:0];
                RA_B_LO: fld_b_q[HALF_W-1:0]     <= wd_half;
                RA_B_HI: fld_b_q[CNT_W-1:HALF_W] <= wd_half;
                RA_C_LO: fld_c_q[HALF_W-1:0]     <= wd_half;
                RA_C_HI: fld_c_q[CNT_W-1:HALF_W] <= wd_half;
                RA_D_LO: fld_d_q[HALF_W-1:0]     <= wd_half;
                RA_D_HI: fld_d_q[CNT_W-1:HALF_W] <= wd_half;
                RA_IEN:  ien_q <= wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_hold_q <= '0;
        else if (rd_en && addr == RA_CNT_LO) hi_hold_q <= count[CNT_W-1:HALF_W];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CNT_LO: rdata = DW'(count[HALF_W-1:0]);
            RA_CNT_HI: rdata = DW'(hi_hold_q);
            RA_CTRL: begin
                rdata[RUN_BIT]  = run_q;
                rdata[FREE_BIT] = free_q;
            end
            RA_STEP:   rdata = DW'(step_q);
            RA_A_LO:   rdata = DW'(field_a[HALF_W-1:0]);
            RA_A_HI:   rdata = DW'(field_a[CNT_W-1:HALF_W]);
            RA_B_LO:   rdata = DW'(fld_b_q[HALF_W-1:0]);
            RA_B_HI:   rdata = DW'(fld_b_q[CNT_W-1:HALF_W]);
            RA_C_LO:   rdata = DW'(fld_c_q[HALF_W-1:0]);
            RA_C_HI:   rdata = DW'(fld_c_q[CNT_W-1:HALF_W]);
            RA_D_LO:   rdata = DW'(fld_d_q[HALF_W-1:0]);
            RA_D_HI:   rdata = DW'(fld_d_q[CNT_W-1:HALF_W]);
            RA_IEN:    rdata = DW'(ien_q);
            RA_STAT: begin
                rdata[NSRC-1:0] = pending;
                rdata[BUSY_BIT] = busy;
            end
            default:   rdata = '0;
        endcase
    end

    wct_counter #(
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W),
        .A_INIT (A_INIT)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run_req  (run_q),
        .free_run (free_q),
        .fld_b    (fld_b_q),
        .fld_c    (fld_c_q),
        .fld_d    (fld_d_q),
        .step     (step_q),
        .a_wr     (a_wr),
        .a_wdata  (a_wdata),
        .count    (count),
        .field_a  (field_a),
        .events   (events)
    );

    wct_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .events   (events),
        .irq_en   (ien_q),
        .clr_wr   (clr_wr),
        .clr_mask (wdata[NSRC-1:0]),
        .pending  (pending),
        .busy     (busy),
        .irq      (irq)
    );
endmodule

// File: rtl/wake_cmp_timer_chk.sv
`timescale 1ns/1ps
module wake_cmp_timer_chk
    import wct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run_q,
    input logic              free_q,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  field_a,
    input logic [STEP_W-1:0] step_q,
    input logic [NSRC-1:0]   events,
    input logic [NSRC-1:0]   pending
);
    // R2
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (count == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && free_q && tick) |=> (count == $past(count) + CNT_W'(1)));

    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((pending & $past(events)) == $past(events)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);

    // R6
    a_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (events[SRC_A] && !(wr_en && (addr == RA_A_LO || addr == RA_A_HI)))
        |=> (field_a == $past(field_a) + CNT_W'($past(step_q))));
endmodule

bind wake_cmp_timer wake_cmp_timer_chk #(
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run_q   (run_q),
    .free_q  (free_q),
    .busy    (busy),
    .wr_en   (wr_en),
    .addr    (addr),
    .count   (count),
    .field_a (field_a),
    .step_q  (step_q),
    .events  (events),
    .pending (pending)
);

// File: tb/wake_cmp_timer_test.sv
`timescale 1ns/1ps
module wake_cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        chk_irq = 1'b0;

    typedef struct {
        logic [15:0] exp;
        logic [15:0] mask;
        bit          is_irq;
        string       tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wake_cmp_timer #(.HALF_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: pops the expected item for every observed read or irq sample
    always @(negedge clk) begin
        if (rd_en || chk_irq) begin
            item_t it;
            logic [15:0] act;
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got %h expected none", rdata);
            end else begin
                it  = q.pop_front();
                act = it.is_irq ? {15'd0, irq} : rdata;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] e,
                          input logic [15:0] m, input string tag);
        item_t it;
        it.exp = e; it.mask = m; it.is_irq = 1'b0; it.tag = tag;
        q.push_back(it);
        addr = a; rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.exp = {15'd0, e}; it.mask = 16'h0001; it.is_irq = 1'b1; it.tag = tag;
        q.push_back(it);
        chk_irq = 1'b1;
        cyc();
        chk_irq = 1'b0;
    endtask

    task automatic ticks(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
            tick = 1'b0;
            if (gap) cyc();
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state, R11 address map
        rd_chk(4'd0,  16'h0000, 16'hFFFF, "R1 count low");
        rd_chk(4'd1,  16'h0000, 16'hFFFF, "R1 count high");
        rd_chk(4'd2,  16'h0040, 16'hFFFF, "R1 control");
        rd_chk(4'd3,  16'h00C8, 16'hFFFF, "R1 interval");
        rd_chk(4'd4,  16'h00C8, 16'hFFFF, "R1 field A low");
        rd_chk(4'd5,  16'h0000, 16'hFFFF, "R1 field A high");
        rd_chk(4'd6,  16'h00FF, 16'hFFFF, "R1 field B low");
        rd_chk(4'd7,  16'h001F, 16'hFFFF, "R1 field B high");
        rd_chk(4'd9,  16'h002F, 16'hFFFF, "R1 field C high");
        rd_chk(4'd11, 16'h003F, 16'hFFFF, "R1 field D high");
        rd_chk(4'd12, 16'h0000, 16'hFFFF, "R1 enable");
        rd_chk(4'd13, 16'h0000, 16'hFFFF, "R1 status");
        irq_chk(1'b0, "R1 irq");

        // configure: A=5 step 4, B=7, C=0x20, D=0x30, free-run enabled
        wr(4'd4, 16'h0005); wr(4'd5, 16'h0000); wr(4'd3, 16'h0004);
        wr(4'd6, 16'h0007); wr(4'd7, 16'h0000);
        wr(4'd8, 16'h0020); wr(4'd9, 16'h0000);
        wr(4'd10, 16'h0030); wr(4'd11, 16'h0000);
        wr(4'd2, 16'h00C0);

        ticks(5, 1);
        rd_chk(4'd0,  16'h0005, 16'hFFFF, "R2 count after five strobes");
        rd_chk(4'd13, 16'h0001, 16'hFFFF, "R3 field A pending while masked");
        rd_chk(4'd4,  16'h0009, 16'hFFFF, "R6 field A advanced by interval");
        irq_chk(1'b0, "R7 masked source keeps irq low");
        wr(4'd12, 16'h0001);
        irq_chk(1'b1, "R7 enabled pending raises irq");

        ticks(2, 1);
        rd_chk(4'd13, 16'h0003, 16'hFFFF, "R3 field B pending");
        ticks(2, 1);
        rd_chk(4'd4,  16'h000D, 16'hFFFF, "R6 field A second reload");

        // R8 delayed clear
        wr(4'd14, 16'h0001);
        rd_chk(4'd13, 16'h0043, 16'hFFFF, "R8 busy after clear write");
        ticks(1, 1);
        rd_chk(4'd13, 16'h0043, 16'hFFFF, "R8 clear pending after one strobe");
        irq_chk(1'b1, "R8 irq held until second strobe");
        ticks(1, 1);
        rd_chk(4'd13, 16'h0002, 16'hFFFF, "R8 cleared after second strobe");
        irq_chk(1'b0, "R7 irq low once cleared");

        // R9 event and clear on the same strobe (count 11 -> 13, A = 13)
        wr(4'd14, 16'h0001);
        ticks(2, 1);
        rd_chk(4'd13, 16'h0003, 16'hFFFF, "R9 event wins over clear");

        // R10 coherent read across low-half rollover
        ticks(242, 0);
        rd_chk(4'd0, 16'h00FF, 16'hFFFF, "R10 low half before rollover");
        ticks(1, 0);
        rd_chk(4'd1, 16'h0000, 16'hFFFF, "R10 high half is latched copy");
        rd_chk(4'd0, 16'h0000, 16'hFFFF, "R10 low half after rollover");
        rd_chk(4'd1, 16'h0001, 16'hFFFF, "R10 high half relatched");

        // R4 full-scale event, R7 enabled on bit 4 only
        wr(4'd12, 16'h0010);
        wr(4'd14, 16'h001F);
        ticks(2, 0);
        ticks(65277, 0);
        rd_chk(4'd13, 16'h0000, 16'h0010, "R4 no full-scale before wrap");
        irq_chk(1'b0, "R7 irq low before wrap");
        ticks(1, 0);
        rd_chk(4'd13, 16'h0010, 16'h0010, "R4 full-scale on wrap");
        irq_chk(1'b1, "R7 irq from full-scale");
        rd_chk(4'd0, 16'h0000, 16'hFFFF, "R4 count wrapped to zero");

        // R2 stop clears the count
        ticks(3, 1);
        wr(4'd2, 16'h0040);
        cyc();
        rd_chk(4'd0, 16'h0000, 16'hFFFF, "R2 count zero after stop");
        ticks(2, 1);
        rd_chk(4'd0, 16'h0000, 16'hFFFF, "R2 count stays zero while stopped");

        // R5 restart mode
        wr(4'd4, 16'h00F0); wr(4'd5, 16'h000F);
        wr(4'd14, 16'h001F);
        ticks(2, 1);
        wr(4'd2, 16'h0080);
        rd_chk(4'd2, 16'h0080, 16'hFFFF, "R5 control restart mode");
        ticks(7, 1);
        rd_chk(4'd0,  16'h0007, 16'hFFFF, "R5 count reaches field B");
        rd_chk(4'd13, 16'h0002, 16'hFFFF, "R5 field B pending only");
        ticks(1, 1);
        rd_chk(4'd0, 16'h0000, 16'hFFFF, "R5 count restarts at zero");
        ticks(7, 1);
        rd_chk(4'd0, 16'h0007, 16'hFFFF, "R5 count climbs again");

        cyc();
        summary();
        $finish;
    end
endmodule